// File: doc/BRIEF.md
# FIFO-Occupancy Latency Allowance Scaler

This block sets the priority that the memory arbiter gives one client, judged by how much room is left in that client's request FIFO. Software loads a base allowance and three percentage breakpoints (low, mid, high). The block turns each breakpoint into an absolute level, computed as the stated fraction of the loaded allowance. It compares the live FIFO free level against those levels and registers an effective allowance. The arbiter reads that value as a priority, and a lower number means more urgent service. When the FIFO is nearly full, the client keeps its whole allowance. When the FIFO is almost empty, the allowance drops to zero.

Scaling is gated by a reference count. Each enable request adds one and each disable request takes one away. A single scaling-on bit follows the count: it rises when the count leaves zero and falls when the count returns to zero. While scaling is off, the base allowance passes straight to the output. Breakpoint writes that are out of order, and disable requests made with nothing left to release, are refused, and each raises an error flag.

Top module: `la_scaler`

## Requirements
- R1: After reset, `eff_la` is 0, `scale_en` is 0, `thr_err` is 0 and `cnt_uf_err` is 0. The stored allowance and all three breakpoints are 0.
- R2: With scaling on and `fifo_free` at or below the low level, `eff_la` equals the stored allowance.
- R3: With scaling on and `fifo_free` above the low level and at or below the mid level, `eff_la` equals the stored allowance shifted right by 1.
- R4: With scaling on and `fifo_free` above the mid level and at or below the high level, `eff_la` equals the stored allowance shifted right by 2.
- R5: With scaling on and `fifo_free` above the high level, `eff_la` is 0.
- R6: Each absolute level equals (percentage × stored allowance) / 100, with the fraction truncated. The levels follow any accepted change of either the percentages or the allowance.
- R7: `scale_inc` adds 1 to the reference count and `scale_dec` subtracts 1. At its maximum the count holds. When both are high in the same cycle, the count does not change. `scale_en` is 1 exactly when the count is nonzero: it is set by the step from 0 to 1 and cleared by the step from 1 to 0.
- R8: A lone `scale_dec` while the count is 0 leaves the count at 0 and sets `cnt_uf_err`. That bit stays set until reset.
- R9: While `scale_en` is 0, `eff_la` equals the stored allowance whatever `fifo_free` is.
- R10: A `thr_load` is accepted only if low ≤ mid ≤ high ≤ 100. A rejected load keeps the old percentages and sets `thr_err`. An accepted load clears `thr_err`.
- R11: A `la_load` while `scale_en` is 1 is ignored, and the stored allowance keeps its value.
- R12: `eff_la` is registered. It reflects the inputs present at the previous rising clock edge, so it changes one cycle after `fifo_free` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| la_load | input | 1 | Store `la_value` as the base allowance |
| la_value | input | LA_W | Base allowance to store |
| thr_load | input | 1 | Store the three breakpoint percentages |
| thr_low_pct | input | PCT_W | Low breakpoint, percent |
| thr_mid_pct | input | PCT_W | Mid breakpoint, percent |
| thr_high_pct | input | PCT_W | High breakpoint, percent |
| scale_inc | input | 1 | Enable request, count up |
| scale_dec | input | 1 | Disable request, count down |
| fifo_free | input | LA_W | Current free level of the client FIFO |
| eff_la | output | LA_W | Effective allowance for the arbiter |
| scale_en | output | 1 | Scaling-on bit |
| thr_err | output | 1 | Last breakpoint load was rejected |
| cnt_uf_err | output | 1 | Sticky count underflow flag |

## Verification
The bench drives `fifo_free` exactly onto each computed level and one step past it. A design with `<` in place of `≤` shows up as the wrong band on one of those boundary values. An allowance of 150 is used so that the percentage products have fractions to truncate. A design that rounds, or that divides after shifting, gives levels that are off by one. The bench also releases more references than it took, then takes a new one. A design whose count wraps below zero leaves `scale_en` stuck high or clears it late. Breakpoint loads that are out of order, and allowance loads made while scaling is on, are sent so that a design that stores them would show a different band afterwards.

// File: rtl/la_scl_pkg.sv
package la_scl_pkg;
  typedef enum logic [1:0] {
    BAND_FULL    = 2'd0,
    BAND_HALF    = 2'd1,
    BAND_QUARTER = 2'd2,
    BAND_ZERO    = 2'd3
  } band_e;

  localparam int unsigned NUM_LEVELS = 3;
  localparam int unsigned PCT_FULL   = 100;
endpackage

// File: rtl/la_scl_thresh.sv
module la_scl_thresh
  import la_scl_pkg::*;
#(
  parameter int unsigned LA_W  = 8,
  parameter int unsigned PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             la_load,
  input  logic [LA_W-1:0]  la_value,
  input  logic             thr_load,
  input  logic [PCT_W-1:0] pct_lo,
  input  logic [PCT_W-1:0] pct_mid,
  input  logic [PCT_W-1:0] pct_hi,
  output logic [LA_W-1:0]  la_q,
  output logic [LA_W-1:0]  lvl_lo,
  output logic [LA_W-1:0]  lvl_mid,
  output logic [LA_W-1:0]  lvl_hi,
  output logic             thr_err_q
);
  localparam int unsigned PROD_W = LA_W + PCT_W;
  localparam logic [PCT_W-1:0]  PCT_MAX = PCT_W'(PCT_FULL);
  localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(PCT_FULL);

  logic [PCT_W-1:0] pct_q [NUM_LEVELS];
  logic [PCT_W-1:0] pct_d [NUM_LEVELS];
  logic [LA_W-1:0]  la_d;
  logic             thr_err_d;
  logic             la_ce;
  logic             thr_ce;
  logic             order_ok;
  logic [LA_W-1:0]  lvl [NUM_LEVELS];

  assign order_ok = (pct_lo <= pct_mid) && (pct_mid <= pct_hi) && (pct_hi <= PCT_MAX);
  assign la_ce    = la_load && !lock;
  assign thr_ce   = thr_load;

  always_comb begin
    la_d      = la_ce ? la_value : la_q;
    thr_err_d = thr_err_q;
    for (int i = 0; i < NUM_LEVELS; i++) pct_d[i] = pct_q[i];
    if (thr_ce) begin
      if (order_ok) begin
        pct_d[0]  = pct_lo;
        pct_d[1]  = pct_mid;
        pct_d[2]  = pct_hi;
        thr_err_d = 1'b0;
      end else begin
        thr_err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q      <= '0;
      thr_err_q <= 1'b0;
      for (int i = 0; i < NUM_LEVELS; i++) pct_q[i] <= '0;
    end else begin
      if (la_ce)  la_q <= la_d;
      if (thr_ce) begin
        thr_err_q <= thr_err_d;
        for (int i = 0; i < NUM_LEVELS; i++) pct_q[i] <= pct_d[i];
      end
    end
  end

  // Absolute levels: percentage of the stored allowance, truncated.
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    assign prod   = PROD_W'(pct_q[g]) * PROD_W'(la_q);
    assign quo    = prod / DIVISOR;
    assign lvl[g] = quo[LA_W-1:0];
  end

  assign lvl_lo  = lvl[0];
  assign lvl_mid = lvl[1];
  assign lvl_hi  = lvl[2];

  assert_pct_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pct_q[0] <= pct_q[1]) && (pct_q[1] <= pct_q[2]) && (pct_q[2] <= PCT_MAX));

  assert_bad_write_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_load && !order_ok) |=> (thr_err_q && $stable(lvl_lo) && $stable(lvl_hi)));

  assert_la_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(la_q));
endmodule

// File: rtl/la_scl_refcnt.sv
module la_scl_refcnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             uf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             en_d;
  logic             uf_d;
  logic             ce;

  assign ce = inc ^ dec;

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    uf_d  = uf_q;
    if (inc && !dec) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
      if (cnt_q == '0)      en_d  = 1'b1;
    end else if (dec && !inc) begin
      if (cnt_q == '0) begin
        uf_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) en_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else if (ce) begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
      uf_q  <= uf_d;
    end
  end

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0 && uf_q));

  assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |=> uf_q);

  assert_en_tracks_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == (cnt_q != '0));

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt_q));
endmodule

// File: rtl/la_scl_band.sv
module la_scl_band
  import la_scl_pkg::*;
#(
  parameter int unsigned LA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [LA_W-1:0] la,
  input  logic [LA_W-1:0] lvl_lo,
  input  logic [LA_W-1:0] lvl_mid,
  input  logic [LA_W-1:0] lvl_hi,
  input  logic [LA_W-1:0] free_lvl,
  output logic [LA_W-1:0] eff_q
);
  band_e           band;
  logic [LA_W-1:0] eff_d;

  always_comb begin
    if (free_lvl <= lvl_lo)       band = BAND_FULL;
    else if (free_lvl <= lvl_mid) band = BAND_HALF;
    else if (free_lvl <= lvl_hi)  band = BAND_QUARTER;
    else                          band = BAND_ZERO;
  end

  always_comb begin
    if (!en) begin
      eff_d = la;
    end else begin
      unique case (band)
        BAND_FULL:    eff_d = la;
        BAND_HALF:    eff_d = la >> 1;
        BAND_QUARTER: eff_d = la >> 2;
        default:      eff_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= '0;
    else        eff_q <= eff_d;
  end

  assert_passthru_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (eff_q == $past(la)));

  assert_zero_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && free_lvl > lvl_hi) |=> (eff_q == '0));

  assert_full_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && free_lvl <= lvl_lo) |=> (eff_q == $past(la)));

  assert_levels_ordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_lo <= lvl_mid) && (lvl_mid <= lvl_hi) && (lvl_hi <= la));
endmodule

// File: rtl/la_scaler.sv
module la_scaler
  import la_scl_pkg::*;
#(
  parameter int unsigned LA_W  = 8,
  parameter int unsigned PCT_W = 7,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             la_load,
  input  logic [LA_W-1:0]  la_value,
  input  logic             thr_load,
  input  logic [PCT_W-1:0] thr_low_pct,
  input  logic [PCT_W-1:0] thr_mid_pct,
  input  logic [PCT_W-1:0] thr_high_pct,
  input  logic             scale_inc,
  input  logic             scale_dec,
  input  logic [LA_W-1:0]  fifo_free,
  output logic [LA_W-1:0]  eff_la,
  output logic             scale_en,
  output logic             thr_err,
  output logic             cnt_uf_err
);
  logic [LA_W-1:0]  la_q;
  logic [LA_W-1:0]  lvl_lo;
  logic [LA_W-1:0]  lvl_mid;
  logic [LA_W-1:0]  lvl_hi;
  logic [CNT_W-1:0] ref_cnt;
  logic             en_q;

  la_scl_refcnt #(.CNT_W(CNT_W)) u_refcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (scale_inc),
    .dec   (scale_dec),
    .cnt_q (ref_cnt),
    .en_q  (en_q),
    .uf_q  (cnt_uf_err)
  );

  la_scl_thresh #(.LA_W(LA_W), .PCT_W(PCT_W)) u_thresh (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (en_q),
    .la_load   (la_load),
    .la_value  (la_value),
    .thr_load  (thr_load),
    .pct_lo    (thr_low_pct),
    .pct_mid   (thr_mid_pct),
    .pct_hi    (thr_high_pct),
    .la_q      (la_q),
    .lvl_lo    (lvl_lo),
    .lvl_mid   (lvl_mid),
    .lvl_hi    (lvl_hi),
    .thr_err_q (thr_err)
  );

  la_scl_band #(.LA_W(LA_W)) u_band (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .la       (la_q),
    .lvl_lo   (lvl_lo),
    .lvl_mid  (lvl_mid),
    .lvl_hi   (lvl_hi),
    .free_lvl (fifo_free),
    .eff_q    (eff_la)
  );

  assign scale_en = en_q;

  assert_en_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scale_en) |-> $past(scale_inc && !scale_dec));

  assert_en_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scale_en) |-> $past(scale_dec && !scale_inc));

  assert_eff_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (eff_la <= $past(la_q)));

  assert_ref_cnt_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(ref_cnt));
endmodule

// File: tb/la_scaler_tb.sv
`timescale 1ns/1ps
module la_scaler_tb_top;
  localparam int LA_W  = 8;
  localparam int PCT_W = 7;
  localparam int CNT_W = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             la_load;
  logic [LA_W-1:0]  la_value;
  logic             thr_load;
  logic [PCT_W-1:0] thr_low_pct, thr_mid_pct, thr_high_pct;
  logic             scale_inc, scale_dec;
  logic [LA_W-1:0]  fifo_free;
  logic [LA_W-1:0]  eff_la;
  logic             scale_en, thr_err, cnt_uf_err;

  always #2.5 clk = ~clk;

  la_scaler #(.LA_W(LA_W), .PCT_W(PCT_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .la_load(la_load), .la_value(la_value),
    .thr_load(thr_load), .thr_low_pct(thr_low_pct), .thr_mid_pct(thr_mid_pct),
    .thr_high_pct(thr_high_pct), .scale_inc(scale_inc), .scale_dec(scale_dec),
    .fifo_free(fifo_free), .eff_la(eff_la), .scale_en(scale_en),
    .thr_err(thr_err), .cnt_uf_err(cnt_uf_err)
  );

  typedef struct {
    int    eff;
    bit    en;
    bit    terr;
    bit    uf;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state, updated from the requirements only
  int m_la, m_cnt;
  int m_p[3];
  bit m_en, m_terr, m_uf;

  function automatic int lvl(int idx);
    return (m_p[idx] * m_la) / 100;
  endfunction

  function automatic int band_eff(int free);
    if (!m_en)            return m_la;
    if (free <= lvl(0))   return m_la;
    if (free <= lvl(1))   return m_la >> 1;
    if (free <= lvl(2))   return m_la >> 2;
    return 0;
  endfunction

  task automatic step(input bit lld, input int lv, input bit tld,
                      input int lo, input int mi, input int hi,
                      input bit inc, input bit dec, input int free,
                      input string tag);
    exp_t e;
    @(negedge clk);
    la_load = lld; la_value = LA_W'(lv);
    thr_load = tld; thr_low_pct = PCT_W'(lo); thr_mid_pct = PCT_W'(mi); thr_high_pct = PCT_W'(hi);
    scale_inc = inc; scale_dec = dec; fifo_free = LA_W'(free);
    e.eff = band_eff(free);
    if (lld && !m_en) m_la = lv;
    if (tld) begin
      if (lo <= mi && mi <= hi && hi <= 100) begin
        m_p[0] = lo; m_p[1] = mi; m_p[2] = hi; m_terr = 1'b0;
      end else m_terr = 1'b1;
    end
    if (inc && !dec) begin
      if (m_cnt < CNT_MAX) m_cnt++;
    end else if (dec && !inc) begin
      if (m_cnt == 0) m_uf = 1'b1; else m_cnt--;
    end
    m_en = (m_cnt != 0);
    e.en = m_en; e.terr = m_terr; e.uf = m_uf; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // Shorthand: only fifo_free changes
  task automatic idle(input int free, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, free, tag);
  endtask

  task automatic cmp(input int act, input int exp, input string what, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle after the edge settles
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(int'(eff_la), e.eff, "eff_la", e.tag);
      cmp(int'(scale_en), int'(e.en), "scale_en", e.tag);
      cmp(int'(thr_err), int'(e.terr), "thr_err", e.tag);
      cmp(int'(cnt_uf_err), int'(e.uf), "cnt_uf_err", e.tag);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    la_load = 0; la_value = 0; thr_load = 0;
    thr_low_pct = 0; thr_mid_pct = 0; thr_high_pct = 0;
    scale_inc = 0; scale_dec = 0; fifo_free = 0;
    m_la = 0; m_cnt = 0; m_p[0] = 0; m_p[1] = 0; m_p[2] = 0;
    m_en = 0; m_terr = 0; m_uf = 0;
    repeat (3) @(posedge clk);
    #1;
    cmp(int'(eff_la), 0, "eff_la", "R1");
    cmp(int'(scale_en), 0, "scale_en", "R1");
    cmp(int'(thr_err), 0, "thr_err", "R1");
    cmp(int'(cnt_uf_err), 0, "cnt_uf_err", "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(0, "R1");
    // Load allowance 200, breakpoints 20/50/80 -> levels 40/100/160
    step(1, 200, 0, 0, 0, 0, 0, 0, 30, "R9");
    step(0, 0, 1, 20, 50, 80, 0, 0, 200, "R9");
    idle(200, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    idle(40,  "R2");
    idle(41,  "R3");
    idle(100, "R3");
    idle(101, "R4");
    idle(160, "R4");
    idle(161, "R5");
    idle(255, "R5");
    idle(0,   "R12");
    // Allowance change while on is ignored
    step(1, 150, 0, 0, 0, 0, 0, 0, 40, "R11");
    idle(41, "R11");
    // Off, load 150, breakpoints 33/67/99 -> 49/100/148
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 150, 1, 33, 67, 99, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    idle(49,  "R6");
    idle(50,  "R6");
    idle(100, "R6");
    idle(101, "R6");
    idle(148, "R6");
    idle(149, "R6");
    // Rejected breakpoint loads
    step(0, 0, 1, 60, 50, 90, 0, 0, 50, "R10");
    idle(101, "R10");
    step(0, 0, 1, 10, 20, 101, 0, 0, 49, "R10");
    step(0, 0, 1, 10, 20, 30, 0, 0, 49, "R10");
    idle(16, "R10");
    // Counting: extra enables, simultaneous, release
    step(0, 0, 0, 0, 0, 0, 1, 0, 16, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 46, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 46, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 46, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, 46, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 0, 46, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 46, "R8");
    idle(46, "R8");
    // Saturation at the maximum count
    for (int i = 0; i < CNT_MAX + 2; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 10, "R7");
    for (int i = 0; i < CNT_MAX; i++)     step(0, 0, 0, 0, 0, 0, 0, 1, 10, "R7");
    idle(10, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule